// File: doc/BRIEF.md
# Predicated Bit-Range Zeroing Unit

This execute-stage datapath takes a 32-bit operand word and forces one contiguous run of its bits to zero, leaving every other bit as it was. The run is given by a low bound and a high bound, both inclusive. The bounds come either from two 5-bit immediates or from two packed 5-bit sub-fields in the low bits of a second register operand. An operation issues as a one-cycle strobe. It takes effect only when its predicate input is true.

The result and its write-enable are registered, so a result is ready on the cycle after issue and a dependent operation can take it at once. When the predicate is false, the write-enable stays low and the registered result keeps its previous value. In register form, if any bound operand bit above bit 9 is set, the unit raises a registered invalid flag. The result computed in that case is not to be relied on.

Top module: `bfclr_unit`

## Requirements
- R1: For issued ops with the predicate true, `res_q` one cycle later equals `opnd_b` with bits lo..hi (inclusive) forced to 0, where bit 0 is the LSB and bit 31 the MSB.
- R2: Bits of `opnd_b` outside lo..hi pass to `res_q` unchanged.
- R3: When lo > hi the cleared range is empty and `res_q` equals `opnd_b`.
- R4: With `use_imm`=1 the bounds are `imm_lo` (low) and `imm_hi` (high), and `opnd_a` has no effect on the result.
- R5: With `use_imm`=0, the high bound is `opnd_a[4:0]` and the low bound is `opnd_a[9:5]`.
- R6: With `use_imm`=0, issue, and a true predicate, `bad_q` is 1 in the next cycle exactly when `opnd_a[31:10]` is nonzero. Otherwise `bad_q` is 0 in the next cycle.
- R7: When the predicate is false or no op issues, `wr_en_q` is 0 in the next cycle and `res_q` keeps its previous value.
- R8: `wr_en_q` is 1 exactly one cycle after an issued op with a true predicate, giving zero delay slots.
- R9: A synchronous active-high `rst` clears `res_q`, `wr_en_q` and `bad_q` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | One-cycle operation strobe |
| pred | input | 1 | Predicate; op takes effect only when 1 |
| use_imm | input | 1 | 1 = immediate bounds, 0 = register bounds |
| imm_lo | input | 5 | Immediate low bound |
| imm_hi | input | 5 | Immediate high bound |
| opnd_a | input | 32 | Register holding packed bounds |
| opnd_b | input | 32 | Word to be modified |
| res_q | output | 32 | Registered result |
| wr_en_q | output | 1 | Registered destination write-enable |
| bad_q | output | 1 | Registered out-of-range bound operand flag |

## Verification
Every one of the 1024 (low, high) bound pairs is run in immediate form against random words. This covers full-width, single-bit and empty (inverted) ranges, and it separates off-by-one errors at either bound from swapped bounds. The same pairs are then run in register form, which shows whether the two sub-fields are swapped or shifted. Register-form runs with high bits set in the bound operand exercise the invalid flag. Ops with a false predicate and idle cycles placed between real ops show that the destination is held and that the write-enable follows the predicate with exactly one cycle of latency.

// File: rtl/bfclr_pkg.sv
package bfclr_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned POS_W  = $clog2(WORD_W);
    localparam int unsigned FLD_W  = 2 * POS_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [POS_W-1:0]  pos_t;

    typedef struct packed {
        word_t res;
        logic  wr_en;
        logic  bad;
    } out_st_t;
endpackage

// File: rtl/bfclr_bounds.sv
module bfclr_bounds
    import bfclr_pkg::*;
(
    input  logic  use_imm,
    input  pos_t  imm_lo,
    input  pos_t  imm_hi,
    input  word_t opnd_a,
    output pos_t  lo,
    output pos_t  hi,
    output logic  over
);
    always_comb begin
        if (use_imm) begin
            lo   = imm_lo;
            hi   = imm_hi;
            over = 1'b0;
        end else begin
            hi   = opnd_a[POS_W-1:0];
            lo   = opnd_a[FLD_W-1:POS_W];
            over = |opnd_a[WORD_W-1:FLD_W];
        end
    end
endmodule

// File: rtl/bfclr_mask.sv
module bfclr_mask
    import bfclr_pkg::*;
(
    input  pos_t  lo,
    input  pos_t  hi,
    output word_t mask
);
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign mask[i] = (pos_t'(i) >= lo) && (pos_t'(i) <= hi);
    end

    // R3
    always_comb begin
        if (lo > hi) empty_range_chk: assert (mask == '0);
    end
endmodule

// File: rtl/bfclr_unit.sv
module bfclr_unit
    import bfclr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        issue,
    input  logic        pred,
    input  logic        use_imm,
    input  logic [4:0]  imm_lo,
    input  logic [4:0]  imm_hi,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    output logic [31:0] res_q,
    output logic        wr_en_q,
    output logic        bad_q
);
    pos_t    lo, hi;
    logic    over;
    word_t   mask;
    out_st_t st_d, st_q;

    bfclr_bounds u_bounds (
        .use_imm(use_imm), .imm_lo(imm_lo), .imm_hi(imm_hi),
        .opnd_a(opnd_a), .lo(lo), .hi(hi), .over(over)
    );

    bfclr_mask u_mask (.lo(lo), .hi(hi), .mask(mask));

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.bad   = 1'b0;
        if (issue && pred) begin
            st_d.res   = opnd_b & ~mask;
            st_d.wr_en = 1'b1;
            st_d.bad   = over;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_q   = st_q.res;
    assign wr_en_q = st_q.wr_en;
    assign bad_q   = st_q.bad;

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(issue && pred) |=> (!wr_en_q && $stable(res_q)));
    // R8
    wr_en_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && pred) |=> wr_en_q);
    // R6
    bad_only_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && pred && use_imm) |=> !bad_q);
    // R2
    outside_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && pred) |=> ((res_q & ~$past(mask)) == ($past(opnd_b) & ~$past(mask))));
    // R1
    inside_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && pred) |=> ((res_q & $past(mask)) == '0));
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (res_q == '0 && !wr_en_q && !bad_q));
endmodule

// File: tb/bfclr_unit_tb.sv
module bfclr_unit_tb;
    logic        clk = 0, rst = 1, issue = 0, pred = 0, use_imm = 0;
    logic [4:0]  imm_lo = 0, imm_hi = 0;
    logic [31:0] opnd_a = 0, opnd_b = 0;
    logic [31:0] res_q;
    logic        wr_en_q, bad_q;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bfclr_unit u_dut (.*);

    function automatic logic [31:0] ref_clr(logic [31:0] w, int lo, int hi);
        logic [31:0] r = w;
        for (int i = 0; i < 32; i++) if (i >= lo && i <= hi) r[i] = 1'b0;
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(bit imm, bit p, int lo, int hi, logic [31:0] a,
                       logic [31:0] b, string req);
        logic [31:0] prev;
        logic [31:0] exp;
        @(negedge clk);
        prev = res_q;
        issue = 1; pred = p; use_imm = imm; imm_lo = 5'(lo); imm_hi = 5'(hi);
        opnd_a = a; opnd_b = b;
        @(negedge clk);
        issue = 0; pred = 0;
        exp = p ? ref_clr(b, lo, hi) : prev;
        chk(req, res_q, exp);
        chk("R8/R7", {31'b0, wr_en_q}, {31'b0, p});
        if (!imm && p) chk("R6", {31'b0, bad_q}, {31'b0, (a[31:10] != 0)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        opnd_b = 32'hFFFF_FFFF; issue = 1; pred = 1; use_imm = 1;
        repeat (2) @(negedge clk);
        issue = 0;
        chk("R9", res_q, 0);
        chk("R9", {30'b0, wr_en_q, bad_q}, 0);
        @(negedge clk); rst = 0;
        // R1 R2 directed example, and R3 inverted range
        run(1, 1, 15, 23, 0, 32'hFFFF_FFFF, "R1");
        run(1, 1, 0, 31, 0, 32'hFFFF_FFFF, "R1");
        run(1, 1, 20, 3, 0, 32'hA5A5_5A5A, "R3");
        // R7: false predicate keeps previous value
        run(1, 0, 0, 31, 0, 32'h1234_5678, "R7");
        // R4: all pairs in immediate form, random src1 ignored
        for (int l = 0; l < 32; l++)
            for (int h = 0; h < 32; h++)
                run(1, 1, l, h, $urandom, $urandom, "R4/R2");
        // R5: all pairs in register form
        for (int l = 0; l < 32; l++)
            for (int h = 0; h < 32; h++)
                run(0, (h % 5) != 0, l, h, {22'b0, 5'(l), 5'(h)}, $urandom, "R5");
        // R6: stray high bits in register operand
        run(0, 1, 4, 9, 32'h0000_0400 | {22'b0, 5'd4, 5'd9}, $urandom, "R6");
        run(0, 1, 1, 30, 32'h8000_0000 | {22'b0, 5'd1, 5'd30}, $urandom, "R6");
        // R7: idle cycle keeps result, wr_en low
        begin
            logic [31:0] keep;
            keep = res_q;
            @(negedge clk);
            chk("R7", res_q, keep);
            chk("R7", {31'b0, wr_en_q}, 0);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule